// File: doc/BRIEF.md
# DSP Register Transfer Unit

This block holds the sixteen-entry general register file of a small 16-bit signal processor and carries out register-to-register moves between those entries. A move is named by an 8-bit opcode that holds a source index and a destination index. Two entries, the accumulator and the product register, are 32 bits wide. A low-accumulator alias reads and writes only the bottom half of the accumulator. Entry 0 is a fixed all-ones constant. One entry is a six-level hardware call stack. Writing it pushes and reading it pops.

The block picks the word half that fits each pairing of widths. Narrow to narrow and wide to wide copy the value as it is. Wide to narrow delivers the high word. Narrow to wide lands in the high word and clears the low word.

A move runs through a three-state controller:
- `S_IDLE`: waits for a strobe with a non-zero opcode and then goes to `S_FETCH`.
- `S_FETCH`: reads the source, pops the stack if the source is the stack, latches the formatted word, and then goes to `S_WRITE`.
- `S_WRITE`: commits the word to the destination or pushes it, and then goes back to `S_IDLE`.

A load port lets the neighbouring datapath write a register directly while the controller is idle. A read port gives a non-destructive view of any entry.

Top module: `dsp_regmove`

## Requirements
- R1: After reset every entry reads 0, except entry 0, which reads 0x0000FFFF. The stack is empty, `mv_busy` is 0 and `stk_err` is 0.
- R2: Entry 0 always reads 0x0000FFFF. Moves and loads aimed at it have no effect.
- R3: The opcode carries the destination in bits 7:4 and the source in bits 3:0. Opcode 0x00 is a no-operation: it is not accepted and `mv_busy` stays low. The index map is:
  - 0: constant
  - 3: accumulator (32 bits)
  - 5: stack
  - 7: product (32 bits)
  - 15: low-accumulator alias
  - all other indices: plain 16-bit registers
- R4: A non-zero opcode strobed while idle is accepted at that clock edge. `mv_busy` is then high for exactly two cycles. The destination takes its new value at the second edge after acceptance. Strobes and opcodes seen while busy are ignored.
- R5: A 16-bit to 16-bit move copies the source's low word, and the source is left unchanged.
- R6: A 32-bit to 32-bit move copies all 32 bits.
- R7: A 32-bit to 16-bit move delivers the source's high word.
- R8: A 16-bit to 32-bit move writes the source word into the destination's high word and clears its low word.
- R9: Index 15 is a 16-bit entry that reads the accumulator's low word. Writing index 15 changes only that low word.
- R10: The stack holds 6 levels in last-in first-out order. A move to index 5 pushes and a move from index 5 pops. The read port shows the top entry without popping it, and shows 0 when the stack is empty.
- R11: A push onto a full stack or a pop from an empty stack sets `stk_err`. The flag stays set until reset, and the stack contents do not change. A pop from an empty stack delivers 0 to the destination.
- R12: A load is taken only while idle and while no move is being accepted in the same cycle. A load writes all 32 bits of a wide entry, the low 16 bits of a narrow entry, and pushes the low 16 bits when aimed at index 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_strobe | input | 1 | Request one move |
| mv_op | input | 8 | Move opcode: destination in bits 7:4, source in bits 3:0 |
| ld_strobe | input | 1 | Direct register load request |
| ld_idx | input | 4 | Load target index |
| ld_data | input | 32 | Load value |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 32 | Read port value, zero-extended for 16-bit entries |
| mv_busy | output | 1 | Move in progress (fetch or write phase) |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
A controller stuck in, or skipping, a phase shows at once on `mv_busy`: the pulse is no longer exactly two cycles long, or a later move's destination never changes. A wrong half selection or a wrong latched word appears on the read port in the cycle after the move's write edge. A stack pointer that drifts shows up at the first pop that follows: the wrong top entry comes back, or `stk_err` rises at a depth other than the one expected.

// File: rtl/dsp_regmove_pkg.sv
package dsp_regmove_pkg;

    localparam int IW = 4;
    localparam int NREG = 16;

    localparam logic [IW-1:0] IDX_ONES = 4'd0;
    localparam logic [IW-1:0] IDX_ACC  = 4'd3;
    localparam logic [IW-1:0] IDX_STK  = 4'd5;
    localparam logic [IW-1:0] IDX_PROD = 4'd7;
    localparam logic [IW-1:0] IDX_ALO  = 4'd15;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_WRITE = 2'd2
    } mv_state_t;

    typedef struct packed {
        logic [IW-1:0] dst;
        logic [IW-1:0] src;
    } mv_op_t;

    function automatic logic is_wide(input logic [IW-1:0] idx);
        return (idx == IDX_ACC) || (idx == IDX_PROD);
    endfunction

endpackage

// File: rtl/dsp_regmove_ctrl.sv
module dsp_regmove_ctrl
    import dsp_regmove_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mv_strobe,
    input  logic [7:0]    mv_op,
    output logic          accept,
    output logic          busy,
    output logic          fetch_ph,
    output logic          write_ph,
    output logic [IW-1:0] src_idx,
    output logic [IW-1:0] dst_idx
);

    mv_state_t state_q, state_d;
    mv_op_t    op_q;
    logic      req_ok;

    assign req_ok = mv_strobe && (mv_op != 8'h00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                op_q <= mv_op_t'(mv_op);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_ok) state_d = S_FETCH;
            S_FETCH: state_d = S_WRITE;
            S_WRITE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        busy     = 1'b0;
        fetch_ph = 1'b0;
        write_ph = 1'b0;
        unique case (state_q)
            S_IDLE:  accept = req_ok;
            S_FETCH: begin
                busy     = 1'b1;
                fetch_ph = 1'b1;
            end
            S_WRITE: begin
                busy     = 1'b1;
                write_ph = 1'b1;
            end
            default: ;
        endcase
    end

    assign src_idx = op_q.src;
    assign dst_idx = op_q.dst;

endmodule

// File: rtl/dsp_regmove_xfer.sv
module dsp_regmove_xfer
    import dsp_regmove_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [IW-1:0]   src_idx,
    input  logic [IW-1:0]   dst_idx,
    input  logic [2*DW-1:0] src_val,
    output logic [2*DW-1:0] fmt_val
);

    localparam int WW = 2 * DW;

    logic src_w, dst_w;

    assign src_w = is_wide(src_idx);
    assign dst_w = is_wide(dst_idx);

    always_comb begin
        unique case ({src_w, dst_w})
            2'b00: fmt_val = {{DW{1'b0}}, src_val[DW-1:0]};
            2'b10: fmt_val = {{DW{1'b0}}, src_val[WW-1:DW]};
            2'b01: fmt_val = {src_val[DW-1:0], {DW{1'b0}}};
            default: fmt_val = src_val;
        endcase
    end

endmodule

// File: rtl/dsp_regmove_stack.sv
module dsp_regmove_stack #(
    parameter int DW    = 16,
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] top,
    output logic          err
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          full, empty, push_ok, pop_ok;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem_q[k] <= '0;
                else if (push_ok && (cnt_q == CW'(k)))
                    mem_q[k] <= push_data;
            end
        end
    endgenerate

    always_comb begin
        top = '0;
        for (int k = 0; k < DEPTH; k++)
            if (cnt_q == CW'(k + 1))
                top = mem_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err   <= 1'b0;
        end else begin
            if (push_ok)
                cnt_q <= cnt_q + 1'b1;
            else if (pop_ok)
                cnt_q <= cnt_q - 1'b1;
            if ((push && full) || (pop && empty))
                err <= 1'b1;
        end
    end

endmodule

// File: rtl/dsp_regmove_regs.sv
module dsp_regmove_regs
    import dsp_regmove_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [2*DW-1:0] wdata,
    input  logic [DW-1:0]   stk_top,
    input  logic [IW-1:0]   ra_idx,
    input  logic [IW-1:0]   rb_idx,
    output logic [2*DW-1:0] ra_data,
    output logic [2*DW-1:0] rb_data
);

    localparam int WW = 2 * DW;

    logic [WW-1:0] view [NREG];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_ent
            if (i == int'(IDX_ONES)) begin : g_ones
                assign view[i] = {{DW{1'b0}}, {DW{1'b1}}};
            end else if (i == int'(IDX_STK)) begin : g_stk
                assign view[i] = {{DW{1'b0}}, stk_top};
            end else if (i == int'(IDX_ALO)) begin : g_alo
                assign view[i] = {{DW{1'b0}}, view[IDX_ACC][DW-1:0]};
            end else if (i == int'(IDX_ACC)) begin : g_acc
                logic [WW-1:0] q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        q <= '0;
                    else if (we && (widx == IDX_ACC))
                        q <= wdata;
                    else if (we && (widx == IDX_ALO))
                        q[DW-1:0] <= wdata[DW-1:0];
                end
                assign view[i] = q;
            end else if (i == int'(IDX_PROD)) begin : g_prod
                logic [WW-1:0] q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        q <= '0;
                    else if (we && (widx == IDX_PROD))
                        q <= wdata;
                end
                assign view[i] = q;
            end else begin : g_nar
                logic [DW-1:0] q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        q <= '0;
                    else if (we && (widx == IW'(i)))
                        q <= wdata[DW-1:0];
                end
                assign view[i] = {{DW{1'b0}}, q};
            end
        end
    endgenerate

    assign ra_data = view[ra_idx];
    assign rb_data = view[rb_idx];

endmodule

// File: rtl/dsp_regmove.sv
module dsp_regmove
    import dsp_regmove_pkg::*;
#(
    parameter int DW        = 16,
    parameter int STK_DEPTH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mv_strobe,
    input  logic [7:0]      mv_op,
    input  logic            ld_strobe,
    input  logic [3:0]      ld_idx,
    input  logic [2*DW-1:0] ld_data,
    input  logic [3:0]      rd_idx,
    output logic [2*DW-1:0] rd_data,
    output logic            mv_busy,
    output logic            stk_err
);

    localparam int WW  = 2 * DW;
    localparam int SCW = $clog2(STK_DEPTH + 1);

    logic          accept, fetch_ph, write_ph;
    logic [IW-1:0] src_idx, dst_idx;
    logic [WW-1:0] src_val, fmt_val, xfer_q;
    logic [DW-1:0] stk_top, push_data;
    logic          ld_ok, mv_we, mv_push, ld_push, pop;
    logic          we;
    logic [IW-1:0] widx;
    logic [WW-1:0] wdata;

    dsp_regmove_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mv_strobe(mv_strobe),
        .mv_op    (mv_op),
        .accept   (accept),
        .busy     (mv_busy),
        .fetch_ph (fetch_ph),
        .write_ph (write_ph),
        .src_idx  (src_idx),
        .dst_idx  (dst_idx)
    );

    dsp_regmove_xfer #(.DW(DW)) u_xfer (
        .src_idx(src_idx),
        .dst_idx(dst_idx),
        .src_val(src_val),
        .fmt_val(fmt_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            xfer_q <= '0;
        else if (fetch_ph)
            xfer_q <= fmt_val;
    end

    assign ld_ok   = ld_strobe && !mv_busy && !accept;
    assign pop     = fetch_ph && (src_idx == IDX_STK);
    assign mv_push = write_ph && (dst_idx == IDX_STK);
    assign mv_we   = write_ph && (dst_idx != IDX_STK) && (dst_idx != IDX_ONES);
    assign ld_push = ld_ok && (ld_idx == IDX_STK);

    always_comb begin
        we    = 1'b0;
        widx  = dst_idx;
        wdata = xfer_q;
        if (mv_we) begin
            we = 1'b1;
        end else if (ld_ok && (ld_idx != IDX_STK) && (ld_idx != IDX_ONES)) begin
            we    = 1'b1;
            widx  = ld_idx;
            wdata = ld_data;
        end
    end

    assign push_data = mv_push ? xfer_q[DW-1:0] : ld_data[DW-1:0];

    dsp_regmove_stack #(.DW(DW), .DEPTH(STK_DEPTH), .CW(SCW)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (mv_push || ld_push),
        .pop      (pop),
        .push_data(push_data),
        .top      (stk_top),
        .err      (stk_err)
    );

    dsp_regmove_regs #(.DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .widx   (widx),
        .wdata  (wdata),
        .stk_top(stk_top),
        .ra_idx (src_idx),
        .rb_idx (rd_idx),
        .ra_data(src_val),
        .rb_data(rd_data)
    );

endmodule

// File: rtl/dsp_regmove_chk.sv
module dsp_regmove_chk #(
    parameter int DW    = 16,
    parameter int DEPTH = 6,
    parameter int CW    = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mv_strobe,
    input logic [7:0]      mv_op,
    input logic [3:0]      rd_idx,
    input logic [2*DW-1:0] rd_data,
    input logic            mv_busy,
    input logic            stk_err,
    input logic [CW-1:0]   stk_cnt
);

    AST_ONES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 4'd0) |-> (rd_data == {{DW{1'b0}}, {DW{1'b1}}})); // R2

    AST_NOP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mv_busy && (!mv_strobe || (mv_op == 8'h00))) |=> !mv_busy); // R3

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!mv_busy && mv_strobe && (mv_op != 8'h00)) |=> mv_busy); // R4

    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_busy && $past(mv_busy)) |=> !mv_busy); // R4

    AST_ALIAS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == 4'd15) |-> (rd_data[2*DW-1:DW] == '0)); // R9

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_cnt <= CW'(DEPTH))); // R10

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err); // R11

endmodule

bind dsp_regmove dsp_regmove_chk #(.DW(DW), .DEPTH(STK_DEPTH), .CW(SCW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mv_strobe(mv_strobe),
    .mv_op    (mv_op),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .mv_busy  (mv_busy),
    .stk_err  (stk_err),
    .stk_cnt  (u_stk.cnt_q)
);

// File: tb/dsp_regmove_bench.sv
`timescale 1ns/1ps
module dsp_regmove_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mv_strobe = 1'b0;
    logic [7:0]  mv_op = 8'h00;
    logic        ld_strobe = 1'b0;
    logic [3:0]  ld_idx = 4'd0;
    logic [31:0] ld_data = 32'h0;
    logic [3:0]  rd_idx = 4'd0;
    logic [31:0] rd_data;
    logic        mv_busy, stk_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dsp_regmove u_dsp_regmove (
        .clk(clk), .rst_n(rst_n), .mv_strobe(mv_strobe), .mv_op(mv_op),
        .ld_strobe(ld_strobe), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .mv_busy(mv_busy), .stk_err(stk_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [3:0] idx, output logic [31:0] v);
        rd_idx = idx;
        #0.5;
        v = rd_data;
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] idx, input logic [31:0] exp);
        logic [31:0] v;
        peek(idx, v);
        chk(tag, v, exp);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_ld(input logic [3:0] idx, input logic [31:0] d);
        ld_strobe = 1'b1;
        ld_idx    = idx;
        ld_data   = d;
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    task automatic do_mv(input logic [7:0] op);
        mv_strobe = 1'b1;
        mv_op     = op;
        @(negedge clk);
        mv_strobe = 1'b0;
        mv_op     = 8'h00;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++)
            chk_reg("R1 reset value", 4'(i), (i == 0) ? 32'h0000FFFF : 32'h0);
        chk("R1 busy after reset", {31'b0, mv_busy}, 32'h0);
        chk("R1 err after reset", {31'b0, stk_err}, 32'h0);
    endtask

    task automatic t_const();
        do_ld(4'd0, 32'h12341234);
        chk_reg("R2 load to constant ignored", 4'd0, 32'h0000FFFF);
        do_ld(4'd1, 32'h00005A5A);
        do_mv(8'h01);
        chk_reg("R2 move to constant ignored", 4'd0, 32'h0000FFFF);
        do_mv(8'h20);
        chk_reg("R2 constant as source", 4'd2, 32'h0000FFFF);
    endtask

    task automatic t_nop_decode();
        do_ld(4'd1, 32'h00001111);
        do_ld(4'd2, 32'h00002222);
        mv_strobe = 1'b1;
        mv_op     = 8'h00;
        @(negedge clk);
        mv_strobe = 1'b0;
        chk("R3 opcode zero not accepted", {31'b0, mv_busy}, 32'h0);
        @(negedge clk);
        chk_reg("R3 opcode zero leaves X", 4'd1, 32'h00001111);
        do_mv(8'h12);
        chk_reg("R3 R5 dst 7:4 gets src 3:0", 4'd1, 32'h00002222);
        chk_reg("R5 source unchanged", 4'd2, 32'h00002222);
    endtask

    task automatic t_timing();
        do_ld(4'd9, 32'h0000AAAA);
        do_ld(4'd10, 32'h00000A0A);
        do_ld(4'd8, 32'h00000808);
        mv_strobe = 1'b1;
        mv_op     = 8'h89;
        @(negedge clk);
        chk("R4 busy in first cycle", {31'b0, mv_busy}, 32'h1);
        mv_op = 8'hA8;
        @(negedge clk);
        chk("R4 busy in second cycle", {31'b0, mv_busy}, 32'h1);
        chk_reg("R4 dest not yet written", 4'd8, 32'h00000808);
        mv_strobe = 1'b0;
        mv_op     = 8'h00;
        @(negedge clk);
        chk("R4 idle after two cycles", {31'b0, mv_busy}, 32'h0);
        chk_reg("R4 dest written", 4'd8, 32'h0000AAAA);
        @(negedge clk);
        chk_reg("R4 strobe during busy ignored", 4'd10, 32'h00000A0A);
    endtask

    task automatic t_widths();
        do_ld(4'd3, 32'h12345678);
        do_mv(8'h73);
        chk_reg("R6 wide to wide", 4'd7, 32'h12345678);
        do_mv(8'h13);
        chk_reg("R7 wide to narrow high word", 4'd1, 32'h00001234);
        do_ld(4'd2, 32'h0000BEEF);
        do_mv(8'h72);
        chk_reg("R8 narrow to wide high word", 4'd7, 32'hBEEF0000);
        do_mv(8'h46);
        chk_reg("R5 narrow to narrow", 4'd4, 32'h0);
    endtask

    task automatic t_alias();
        chk_reg("R9 alias reads acc low", 4'd15, 32'h00005678);
        do_mv(8'hF2);
        chk_reg("R9 alias write keeps acc high", 4'd3, 32'h1234BEEF);
        do_mv(8'h1F);
        chk_reg("R9 alias is a narrow source", 4'd1, 32'h0000BEEF);
        do_ld(4'd15, 32'h77779999);
        chk_reg("R9 R12 alias load low only", 4'd3, 32'h12349999);
    endtask

    task automatic t_stack();
        chk_reg("R10 empty stack reads zero", 4'd5, 32'h0);
        do_ld(4'd1, 32'h00000001);
        do_mv(8'h51);
        chk_reg("R10 push visible at top", 4'd5, 32'h00000001);
        do_mv(8'h52);
        chk_reg("R10 second push on top", 4'd5, 32'h0000BEEF);
        chk_reg("R10 peek does not pop", 4'd5, 32'h0000BEEF);
        do_mv(8'h85);
        chk_reg("R10 pop returns last pushed", 4'd8, 32'h0000BEEF);
        chk_reg("R10 top after pop", 4'd5, 32'h00000001);
        do_mv(8'h53);
        chk_reg("R7 R10 wide push gives high word", 4'd5, 32'h00001234);
        do_mv(8'h35);
        chk_reg("R8 R10 pop into wide", 4'd3, 32'h12340000);
        do_mv(8'h85);
        chk_reg("R10 pop first pushed", 4'd8, 32'h00000001);
        chk_reg("R10 empty again", 4'd5, 32'h0);
        chk("R11 no error on legal use", {31'b0, stk_err}, 32'h0);
    endtask

    task automatic t_load();
        do_ld(4'd7, 32'hCAFEF00D);
        chk_reg("R12 wide load full", 4'd7, 32'hCAFEF00D);
        do_ld(4'd1, 32'hCAFEF00D);
        chk_reg("R12 narrow load low", 4'd1, 32'h0000F00D);
        do_ld(4'd2, 32'h00000002);
        mv_strobe = 1'b1;
        mv_op     = 8'h12;
        ld_strobe = 1'b1;
        ld_idx    = 4'd11;
        ld_data   = 32'h00004444;
        @(negedge clk);
        mv_strobe = 1'b0;
        mv_op     = 8'h00;
        ld_idx    = 4'd12;
        @(negedge clk);
        ld_strobe = 1'b0;
        @(negedge clk);
        chk_reg("R12 load beside accept ignored", 4'd11, 32'h0);
        chk_reg("R12 load while busy ignored", 4'd12, 32'h0);
        chk_reg("R12 move still done", 4'd1, 32'h00000002);
    endtask

    task automatic t_errors();
        for (int i = 0; i < 6; i++)
            do_ld(4'd5, 32'h100 + 32'(i));
        chk("R11 full stack no error yet", {31'b0, stk_err}, 32'h0);
        chk_reg("R10 sixth level top", 4'd5, 32'h00000105);
        do_ld(4'd5, 32'h00000777);
        chk("R11 overflow sets error", {31'b0, stk_err}, 32'h1);
        chk_reg("R11 overflow leaves top", 4'd5, 32'h00000105);
        for (int i = 0; i < 6; i++) begin
            do_mv(8'hA5);
            chk_reg("R10 R11 lifo drain", 4'd10, 32'h105 - 32'(i));
        end
        do_ld(4'd9, 32'h00003333);
        do_mv(8'h95);
        chk_reg("R11 underflow delivers zero", 4'd9, 32'h0);
        chk("R11 error sticky", {31'b0, stk_err}, 32'h1);
        chk_reg("R11 stack still empty", 4'd5, 32'h0);
    endtask

    initial begin
        apply_reset();
        t_reset();
        t_const();
        t_nop_decode();
        t_timing();
        t_widths();
        t_alias();
        t_stack();
        t_load();
        apply_reset();
        t_errors();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule